// File: doc/BRIEF.md
# DDR2 Burst Interrupt Rule Monitor

This block watches the command bus of a DDR2-style memory controller and reports commands that break the rules for cutting a burst short or for closing a bank too soon after a read or write. Each clock it samples one decoded command, its bank address and its auto-precharge flag. Static configuration inputs carry the programmed burst length (4 or 8), the additive latency, the write latency and the write recovery time. The configuration is expected to change only while reset is held.

The monitor tracks the most recent read or write as the open burst. A later read, write or precharge that lands before that burst's last data slot counts as an interrupt. With burst length 8 a burst may be cut short only by a command of the same kind (read by read, write by write), only exactly two cycles after the command it interrupts, and never when the open burst carries auto-precharge. The interrupting command may target any bank. For each bank the monitor also keeps the minimum precharge spacing of the latest read or write to that bank. The spacing always uses the full programmed burst length, even when the burst was cut short.

Commands are sampled every cycle. There is no handshake and no back-pressure: the monitor never stalls the controller, and a NOP or any other command slot is simply observed. Each violation produces a single-cycle pulse together with a rule code.

Top module: `burst_rule_mon`

## Requirements
- R1: A synchronous active-high reset clears the outputs to zero and forgets every open burst and every pending precharge spacing. After reset, a precharge to a bank used before the reset is legal, and a read issued next is treated as a fresh burst.
- R2: With burst length 8, a write or a precharge issued inside an open read burst is flagged with rule code 2.
- R3: With burst length 8, a read or a precharge issued inside an open write burst is flagged with rule code 2.
- R4: With burst length 4, any read, write or precharge issued one cycle after a read or write is flagged with rule code 1. This code takes precedence over code 2.
- R5: With burst length 8, a read that interrupts a read burst, or a write that interrupts a write burst, exactly two cycles after that burst's command is legal. This holds for any bank and holds when the interrupting command itself carries auto-precharge.
- R6: With burst length 8, a same-kind interrupt at one or three cycles after the burst's command is flagged with rule code 3.
- R7: A same-kind interrupt of a burst whose command carried auto-precharge is flagged with rule code 4, even at the two-cycle slot.
- R8: A read or write issued burst-length/2 or more cycles after the latest read or write starts an ordinary burst and raises no violation.
- R9: A precharge to a bank fewer than AL + BL/2 cycles after the latest read to that bank is flagged with rule code 5. At exactly AL + BL/2 cycles it is legal. BL is the programmed burst length.
- R10: A precharge to a bank fewer than WL + BL/2 + tWR cycles after the latest write to that bank is flagged with rule code 6. The count starts at the write command, whether or not that write burst was cut short.
- R11: Precharge spacing uses only the most recent read or write to the precharged bank. A later read or write to the same bank replaces the earlier requirement, and commands to other banks have no effect.
- R12: The violation flag and rule code are registered: they appear in the cycle after the offending command, last one cycle, and read zero (code 0) for a legal command, a NOP (code 0) or any other command (codes 4 to 7). Command codes are NOP 0, READ 1, WRITE 2, PRECHARGE 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Decoded command: 0 NOP, 1 READ, 2 WRITE, 3 PRECHARGE, 4-7 other |
| bank_i | input | BANK_W (2) | Bank addressed by the command |
| auto_pre_i | input | 1 | Auto-precharge flag of a read or write |
| bl8_i | input | 1 | Programmed burst length: 1 for 8, 0 for 4 |
| add_lat_i | input | LAT_W (3) | Additive latency in cycles |
| wr_lat_i | input | LAT_W (3) | Write latency in cycles |
| wr_rec_i | input | LAT_W (3) | Write recovery time in cycles |
| viol_o | output | 1 | One-cycle pulse when a rule is broken |
| rule_o | output | 3 | Broken rule: 0 none, 1 interrupt at BL4, 2 wrong command kind, 3 wrong slot, 4 auto-precharge burst, 5 early precharge after read, 6 early precharge after write |

## Verification
The verdict on a command sampled at one rising edge is registered at that same edge, so it is due exactly one cycle after the command is presented. The bench drives each command at a falling edge and reads the outputs at the next falling edge. Every step therefore checks the verdict of the command it just issued, and the following NOP step confirms that the pulse has ended. Interrupt slots and precharge spacings are counted in these one-cycle steps from the read or write that opens them. The boundary steps (slot 2 compared with slots 1 and 3, a spacing one short of the requirement compared with exactly met) each fall on a known step.

// File: rtl/burst_rule_pkg.sv
package burst_rule_pkg;

  localparam logic [2:0] CMD_NOP = 3'd0;
  localparam logic [2:0] CMD_RD  = 3'd1;
  localparam logic [2:0] CMD_WR  = 3'd2;
  localparam logic [2:0] CMD_PRE = 3'd3;

  // the only cycle offset at which a same-kind interrupt is allowed
  localparam int LEGAL_OFS = 2;

  typedef enum logic [2:0] {
    RULE_NONE    = 3'd0,
    RULE_BL4     = 3'd1,
    RULE_TYPE    = 3'd2,
    RULE_SLOT    = 3'd3,
    RULE_AUTOPRE = 3'd4,
    RULE_PRE_RD  = 3'd5,
    RULE_PRE_WR  = 3'd6
  } rule_e;

endpackage

// File: rtl/burst_window.sv
// Tracks the latest read/write as the open burst and its age in cycles.
module burst_window #(
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  input  logic             start_ap,
  input  logic             bl8,
  output logic             in_window,
  output logic [OFS_W-1:0] offset,
  output logic             burst_wr,
  output logic             burst_ap
);

  logic             seen_q;
  logic [OFS_W-1:0] age_q;
  logic             wr_q;
  logic             ap_q;
  logic [OFS_W-1:0] last_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      age_q  <= '0;
      wr_q   <= 1'b0;
      ap_q   <= 1'b0;
    end else if (start) begin
      seen_q <= 1'b1;
      age_q  <= OFS_W'(1);
      wr_q   <= start_wr;
      ap_q   <= start_ap;
    end else if (seen_q && (age_q != '1)) begin
      age_q <= age_q + OFS_W'(1);
    end
  end

  // window covers offsets 1 .. BL/2-1
  assign last_slot = bl8 ? OFS_W'(3) : OFS_W'(1);
  assign in_window = seen_q && (age_q <= last_slot);
  assign offset    = age_q;
  assign burst_wr  = wr_q;
  assign burst_ap  = ap_q;

endmodule

// File: rtl/bank_timers.sv
// One down-counter per bank holding the cycles left before a precharge is legal.
module bank_timers #(
  parameter int NUM_BANKS = 4,
  parameter int TMR_W     = 5,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [BANK_W-1:0]    load_bank,
  input  logic [TMR_W-1:0]     load_val,
  input  logic                 load_wr,
  output logic [NUM_BANKS-1:0] ready,
  output logic [NUM_BANKS-1:0] last_wr
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TMR_W-1:0] cnt_q;
    logic             wr_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
        wr_q  <= 1'b0;
      end else if (load && (load_bank == BANK_W'(b))) begin
        cnt_q <= load_val;
        wr_q  <= load_wr;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - TMR_W'(1);
      end
    end

    assign ready[b]   = (cnt_q == '0);
    assign last_wr[b] = wr_q;
  end

endmodule

// File: rtl/rule_eval.sv
// Combinational priority of the burst and precharge rules.
module rule_eval
  import burst_rule_pkg::*;
#(
  parameter int OFS_W = 3
) (
  input  logic [2:0]       cmd,
  input  logic             bl8,
  input  logic             in_window,
  input  logic [OFS_W-1:0] offset,
  input  logic             burst_wr,
  input  logic             burst_ap,
  input  logic             tgt_ready,
  input  logic             tgt_last_wr,
  output rule_e            rule
);

  logic is_rd, is_wr, is_pre;

  assign is_rd  = (cmd == CMD_RD);
  assign is_wr  = (cmd == CMD_WR);
  assign is_pre = (cmd == CMD_PRE);

  always_comb begin
    rule = RULE_NONE;
    if (in_window && (is_rd || is_wr || is_pre)) begin
      if (!bl8)                              rule = RULE_BL4;
      else if (is_pre || (is_wr != burst_wr)) rule = RULE_TYPE;
      else if (burst_ap)                     rule = RULE_AUTOPRE;
      else if (offset != OFS_W'(LEGAL_OFS))  rule = RULE_SLOT;
    end else if (is_pre && !tgt_ready) begin
      rule = tgt_last_wr ? RULE_PRE_WR : RULE_PRE_RD;
    end
  end

endmodule

// File: rtl/burst_rule_mon.sv
module burst_rule_mon
  import burst_rule_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int LAT_W     = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int TMR_W    = LAT_W + 2,
  localparam int OFS_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              auto_pre_i,
  input  logic              bl8_i,
  input  logic [LAT_W-1:0]  add_lat_i,
  input  logic [LAT_W-1:0]  wr_lat_i,
  input  logic [LAT_W-1:0]  wr_rec_i,
  output logic              viol_o,
  output logic [2:0]        rule_o
);

  logic                 is_rd, is_wr, is_rw;
  logic [TMR_W-1:0]     half_bl, need_rd, need_wr, load_val;
  logic                 in_window, burst_wr, burst_ap;
  logic [OFS_W-1:0]     offset;
  logic [NUM_BANKS-1:0] ready, last_wr;
  rule_e                rule;
  logic                 viol_q;
  rule_e                rule_q;

  assign is_rd = (cmd_i == CMD_RD);
  assign is_wr = (cmd_i == CMD_WR);
  assign is_rw = is_rd || is_wr;

  // spacing always uses the programmed burst length
  assign half_bl  = bl8_i ? TMR_W'(4) : TMR_W'(2);
  assign need_rd  = TMR_W'(add_lat_i) + half_bl;
  assign need_wr  = TMR_W'(wr_lat_i) + half_bl + TMR_W'(wr_rec_i);
  assign load_val = (is_wr ? need_wr : need_rd) - TMR_W'(1);

  burst_window #(.OFS_W(OFS_W)) u_window (
    .clk       (clk),
    .rst       (rst),
    .start     (is_rw),
    .start_wr  (is_wr),
    .start_ap  (auto_pre_i),
    .bl8       (bl8_i),
    .in_window (in_window),
    .offset    (offset),
    .burst_wr  (burst_wr),
    .burst_ap  (burst_ap)
  );

  bank_timers #(.NUM_BANKS(NUM_BANKS), .TMR_W(TMR_W)) u_timers (
    .clk       (clk),
    .rst       (rst),
    .load      (is_rw),
    .load_bank (bank_i),
    .load_val  (load_val),
    .load_wr   (is_wr),
    .ready     (ready),
    .last_wr   (last_wr)
  );

  rule_eval #(.OFS_W(OFS_W)) u_eval (
    .cmd         (cmd_i),
    .bl8         (bl8_i),
    .in_window   (in_window),
    .offset      (offset),
    .burst_wr    (burst_wr),
    .burst_ap    (burst_ap),
    .tgt_ready   (ready[bank_i]),
    .tgt_last_wr (last_wr[bank_i]),
    .rule        (rule)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_q <= 1'b0;
      rule_q <= RULE_NONE;
    end else begin
      viol_q <= (rule != RULE_NONE);
      rule_q <= rule;
    end
  end

  assign viol_o = viol_q;
  assign rule_o = rule_q;

endmodule

// File: rtl/burst_rule_mon_chk.sv
module burst_rule_mon_chk
  import burst_rule_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] cmd_i,
  input logic       auto_pre_i,
  input logic       bl8_i,
  input logic       viol_o,
  input logic [2:0] rule_o
);

  logic [2:0] q1_cmd, q2_cmd;
  logic       q1_ap, q2_ap;
  logic       q1_rw, q2_rw;

  always_ff @(posedge clk) begin
    if (rst) begin
      q1_cmd <= CMD_NOP;
      q2_cmd <= CMD_NOP;
      q1_ap  <= 1'b0;
      q2_ap  <= 1'b0;
    end else begin
      q1_cmd <= cmd_i;
      q2_cmd <= q1_cmd;
      q1_ap  <= auto_pre_i;
      q2_ap  <= q1_ap;
    end
  end

  assign q1_rw = (q1_cmd == CMD_RD) || (q1_cmd == CMD_WR);
  assign q2_rw = (q2_cmd == CMD_RD) || (q2_cmd == CMD_WR);

  // R12: an idle or unrelated command slot never raises a flag
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_NOP || cmd_i[2]) |=> !viol_o);

  // R4
  p_bl4_cut_r4: assert property (@(posedge clk) disable iff (rst)
    (!bl8_i && q1_rw && (cmd_i == CMD_RD || cmd_i == CMD_WR || cmd_i == CMD_PRE))
    |=> (viol_o && rule_o == 3'd1));

  // R2
  p_rd_cut_type_r2: assert property (@(posedge clk) disable iff (rst)
    (bl8_i && q1_cmd == CMD_RD && (cmd_i == CMD_WR || cmd_i == CMD_PRE))
    |=> (viol_o && rule_o == 3'd2));

  // R3
  p_wr_cut_type_r3: assert property (@(posedge clk) disable iff (rst)
    (bl8_i && q1_cmd == CMD_WR && (cmd_i == CMD_RD || cmd_i == CMD_PRE))
    |=> (viol_o && rule_o == 3'd2));

  // R6
  p_early_slot_r6: assert property (@(posedge clk) disable iff (rst)
    (bl8_i && q1_rw && !q1_ap && cmd_i == q1_cmd)
    |=> (viol_o && rule_o == 3'd3));

  // R5
  p_legal_slot_r5: assert property (@(posedge clk) disable iff (rst)
    (bl8_i && q2_rw && !q2_ap && !q1_rw && cmd_i == q2_cmd) |=> !viol_o);

  // R7
  p_autopre_cut_r7: assert property (@(posedge clk) disable iff (rst)
    (bl8_i && q2_rw && q2_ap && !q1_rw && cmd_i == q2_cmd)
    |=> (viol_o && rule_o == 3'd4));

endmodule

bind burst_rule_mon burst_rule_mon_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_i      (cmd_i),
  .auto_pre_i (auto_pre_i),
  .bl8_i      (bl8_i),
  .viol_o     (viol_o),
  .rule_o     (rule_o)
);

// File: tb/burst_rule_mon_tb.sv
module burst_rule_mon_tb;

  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] NOP = 3'd0;
  localparam logic [2:0] RD  = 3'd1;
  localparam logic [2:0] WR  = 3'd2;
  localparam logic [2:0] PRE = 3'd3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = 2'd0;
  logic       ap = 1'b0;
  logic       bl8 = 1'b1;
  logic [2:0] al = 3'd0;
  logic [2:0] wl = 3'd2;
  logic [2:0] twr = 3'd3;
  logic       viol;
  logic [2:0] rule;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_rule_mon u_dut (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd),
    .bank_i     (bank),
    .auto_pre_i (ap),
    .bl8_i      (bl8),
    .add_lat_i  (al),
    .wr_lat_i   (wl),
    .wr_rec_i   (twr),
    .viol_o     (viol),
    .rule_o     (rule)
  );

  task automatic check(input logic [2:0] exp, input string tag);
    n_chk++;
    if (viol !== (exp != 3'd0) || rule !== exp) begin
      n_fail++;
      $display("FAIL %s: viol=%0b rule=%0d expected viol=%0b rule=%0d",
               tag, viol, rule, (exp != 3'd0), exp);
    end
  endtask

  // present one command at a falling edge, check its verdict one cycle later
  task automatic step(input logic [2:0] c, input logic [1:0] b, input logic a,
                      input logic [2:0] exp, input string tag);
    cmd = c; bank = b; ap = a;
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(NOP, 2'd0, 1'b0, 3'd0, tag);
  endtask

  task automatic do_reset(input logic b8, input logic [2:0] a, input logic [2:0] w,
                          input logic [2:0] r);
    rst = 1'b1; cmd = NOP; ap = 1'b0;
    bl8 = b8; al = a; wl = w; twr = r;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b1, 3'd0, 3'd2, 3'd3);
    check(3'd0, "R1 outputs after reset");
    step(RD, 2'd0, 1'b0, 3'd0, "R1 first read");
    do_reset(1'b1, 3'd0, 3'd2, 3'd3);
    step(PRE, 2'd0, 1'b0, 3'd0, "R1 precharge spacing cleared");
    step(RD, 2'd1, 1'b0, 3'd0, "R1 open burst cleared");
  endtask

  task automatic t_legal();
    do_reset(1'b1, 3'd0, 3'd2, 3'd3);
    step(RD, 2'd0, 1'b0, 3'd0, "R5 read");
    idle(1, "R5 gap");
    step(RD, 2'd3, 1'b1, 3'd0, "R5 read cut at slot 2 other bank with auto-pre");
    idle(3, "R5 tail");
    step(WR, 2'd1, 1'b0, 3'd0, "R8 write after window");
    idle(1, "R5 gap");
    step(WR, 2'd2, 1'b0, 3'd0, "R5 write cut at slot 2");
  endtask

  task automatic t_type();
    do_reset(1'b1, 3'd0, 3'd2, 3'd3);
    step(RD, 2'd0, 1'b0, 3'd0, "R2 read");
    step(WR, 2'd1, 1'b0, 3'd2, "R2 write inside read burst");
    idle(1, "R12 pulse ended");
    step(PRE, 2'd1, 1'b0, 3'd2, "R3 precharge inside write burst");
    do_reset(1'b1, 3'd0, 3'd2, 3'd3);
    step(RD, 2'd0, 1'b0, 3'd0, "R2 read");
    idle(1, "R2 gap");
    step(PRE, 2'd2, 1'b0, 3'd2, "R2 precharge inside read burst");
    do_reset(1'b1, 3'd0, 3'd2, 3'd3);
    step(WR, 2'd0, 1'b0, 3'd0, "R3 write");
    step(RD, 2'd0, 1'b0, 3'd2, "R3 read inside write burst");
  endtask

  task automatic t_slot();
    do_reset(1'b1, 3'd0, 3'd2, 3'd3);
    step(WR, 2'd0, 1'b0, 3'd0, "R6 write");
    step(WR, 2'd0, 1'b0, 3'd3, "R6 write at slot 1");
    idle(3, "R12 quiet after pulse");
    step(WR, 2'd1, 1'b0, 3'd0, "R8 write at BL/2");
    idle(2, "R6 gap");
    step(WR, 2'd2, 1'b0, 3'd3, "R6 write at slot 3");
  endtask

  task automatic t_autopre();
    do_reset(1'b1, 3'd0, 3'd2, 3'd3);
    step(RD, 2'd0, 1'b1, 3'd0, "R7 read with auto-pre");
    idle(1, "R7 gap");
    step(RD, 2'd1, 1'b0, 3'd4, "R7 read cuts auto-pre burst");
    idle(3, "R7 tail");
    step(WR, 2'd2, 1'b1, 3'd0, "R8 write with auto-pre after window");
    idle(1, "R7 gap");
    step(WR, 2'd3, 1'b0, 3'd4, "R7 write cuts auto-pre burst");
  endtask

  task automatic t_bl4();
    do_reset(1'b0, 3'd0, 3'd2, 3'd3);
    step(RD, 2'd0, 1'b0, 3'd0, "R4 read");
    step(WR, 2'd1, 1'b0, 3'd1, "R4 write at slot 1 takes code 1");
    idle(1, "R4 gap");
    step(RD, 2'd2, 1'b0, 3'd0, "R8 read at BL/2 with BL4");
    step(PRE, 2'd3, 1'b0, 3'd1, "R4 precharge at slot 1");
    step(RD, 2'd3, 1'b0, 3'd0, "R8 read at BL/2 with BL4");
    step(RD, 2'd0, 1'b0, 3'd1, "R4 read at slot 1");
  endtask

  task automatic t_pre_rd();
    do_reset(1'b1, 3'd1, 3'd2, 3'd3);
    step(RD, 2'd1, 1'b0, 3'd0, "R9 read AL=1");
    idle(3, "R9 burst");
    step(PRE, 2'd1, 1'b0, 3'd5, "R9 precharge one short");
    step(PRE, 2'd1, 1'b0, 3'd0, "R9 precharge at AL+BL/2");
    do_reset(1'b1, 3'd0, 3'd2, 3'd3);
    step(RD, 2'd1, 1'b0, 3'd0, "R9 read AL=0");
    idle(3, "R9 burst");
    step(PRE, 2'd1, 1'b0, 3'd0, "R9 precharge at BL/2 with AL=0");
  endtask

  task automatic t_pre_wr();
    do_reset(1'b1, 3'd0, 3'd2, 3'd3);
    step(WR, 2'd0, 1'b0, 3'd0, "R10 write bank 0");
    idle(1, "R10 gap");
    step(WR, 2'd1, 1'b0, 3'd0, "R10 interrupting write bank 1");
    idle(5, "R10 wait");
    step(PRE, 2'd0, 1'b0, 3'd6, "R10 bank 0 precharge at 8 of 9");
    step(PRE, 2'd0, 1'b0, 3'd0, "R10 bank 0 precharge at 9");
    step(PRE, 2'd1, 1'b0, 3'd6, "R11 bank 1 precharge 8 after its write");
    step(PRE, 2'd1, 1'b0, 3'd0, "R11 bank 1 precharge 9 after its write");
  endtask

  task automatic t_recent();
    do_reset(1'b1, 3'd0, 3'd2, 3'd3);
    step(WR, 2'd2, 1'b0, 3'd0, "R11 write bank 2");
    idle(3, "R11 burst");
    step(RD, 2'd2, 1'b0, 3'd0, "R11 read bank 2");
    idle(3, "R11 burst");
    step(PRE, 2'd2, 1'b0, 3'd0, "R11 precharge uses latest read");
    step(PRE, 2'd3, 1'b0, 3'd0, "R11 untouched bank");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_legal();
    t_type();
    t_slot();
    t_autopre();
    t_bl4();
    t_pre_rd();
    t_pre_wr();
    t_recent();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule